// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Target

This block is the target side of a two-wire serial bus in front of a 256-byte storage array. The clock and data lines arrive already synchronized to the system clock. The block answers with a single open-drain pull-down request: when `sda_drive_o` is high, the pad pulls the data line low. A three-bit strap selects which of eight bus identities the block answers to. A protect input blocks all writes.

A master addresses the block with an identity byte and may follow it with a one-byte word address. It can then store one byte, or a burst of up to eight bytes that stay inside one 8-byte page. It can also read from the internal address counter, read from an address it has just loaded, or stream bytes for as long as it keeps acknowledging. After a committed write the block goes deaf to the bus for a parameterized number of clock cycles. The master detects the end of this window by sending the identity byte until it is acknowledged.

Top module: `twi_eeprom_slave`

## Requirements
- R1: The identity byte is taken MSB first. Bits 7:4 must equal 1010 and bits 3:1 must equal `sel_i`. Bit 0 selects the direction: 1 is read, 0 is write. Any other identity gets no acknowledge, and the block waits for the next start.
- R2: Each byte the block accepts is acknowledged by pulling the data line low for the whole ninth clock pulse. The block releases the line after that pulse, and a start condition always leaves the line released.
- R3: Incoming bits are taken on the rising clock edge. The block changes its pull-down only while the clock line is low. Read data is sent MSB first.
- R4: The sequence identity(write), word address, one data byte, stop stores the byte at the word address.
- R5: A write burst holds its data bytes until the stop. Only the low 3 address bits advance; the upper 5 bits stay fixed. A ninth or later byte wraps to the start of the same page and replaces the earlier byte at that position.
- R6: A stop that ends a committed write opens a busy window of `WR_CYCLES` clock cycles. During the window the block ignores the bus and acknowledges no identity byte. After the window an identity byte is acknowledged again.
- R7: The address counter resets to 0 and always holds the last accessed address plus one. A read that starts directly after the identity byte returns the byte at the counter.
- R8: A word address followed by a repeated start and identity(read) returns the byte at that word address. Loading an address without data starts no busy window.
- R9: A read continues with the next address while the master acknowledges each byte, and the address wraps from 255 to 0. A master non-acknowledge ends the read.
- R10: With `wp_i` high at the stop, every byte is still acknowledged, but nothing is stored and no busy window starts.
- R11: A start or stop that arrives after more than one bit of a data byte aborts the transaction. Nothing is stored and no busy window starts.
- R12: Reset fills the array with 0xFF, clears the counter and releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line (wired level) |
| sel_i | input | 3 | Strapped identity select |
| wp_i | input | 1 | Write protect, high blocks storing |
| sda_drive_o | output | 1 | High requests the pad to pull the data line low |

## Verification
The assertions assume that bus edges arrive several system cycles apart. They also assume that the master never makes the data line rise or fall while the clock line is high, except to form a start or stop. The clock-line check only holds if the clock stays low for at least three system cycles after each falling edge. The stimulus keeps within these limits: it changes only one line per ten-cycle step, and it alters the data line only while the clock is low, except in the start and stop tasks.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

    localparam logic [3:0] ID_CODE = 4'b1010;
    localparam int         SEL_W   = 3;
    localparam int         BYTE_W  = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_RNEXT,
        ST_BUSY
    } ctl_st_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

endpackage

// File: rtl/twi_ee_line_mon.sv
module twi_ee_line_mon
    import twi_ee_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } mon_t;

    mon_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.scl = scl_i;
        nxt_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{scl: 1'b1, sda: 1'b1};
        else        cur_q <= nxt_d;
    end

    // Clock edges, plus data edges while the clock stays high
    assign ev_o.rise  = scl_i & ~cur_q.scl;
    assign ev_o.fall  = ~scl_i & cur_q.scl;
    assign ev_o.start = scl_i & cur_q.scl & cur_q.sda & ~sda_i;
    assign ev_o.stop  = scl_i & cur_q.scl & ~cur_q.sda & sda_i;
    assign ev_o.sda   = sda_i;

endmodule

// File: rtl/twi_ee_store.sv
module twi_ee_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] rows;

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  word_q <= '1;
            else if (we_i && waddr_i == ADDR_W'(g))     word_q <= wdata_i;
        end
        assign rows[g] = word_q;
    end

    assign rdata_o = rows[raddr_i];

endmodule

// File: rtl/twi_ee_ctrl.sv
module twi_ee_ctrl
    import twi_ee_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  line_ev_t          ev_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              wp_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              busy_o,
    output logic              sda_drive_o
);

    localparam int PAGE_N = 1 << PAGE_W;
    localparam int TMR_W  = $clog2(WR_CYCLES + 1) > PAGE_W + 1 ?
                            $clog2(WR_CYCLES + 1) : PAGE_W + 1;

    typedef struct packed {
        ctl_st_e                      st;
        logic [3:0]                   cnt;
        logic [BYTE_W-1:0]            sh;
        logic                         drv;
        logic [ADDR_W-1:0]            ptr;
        logic [PAGE_N-1:0][BYTE_W-1:0] pbuf;
        logic [PAGE_N-1:0]            mask;
        logic [TMR_W-1:0]             tmr;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:   ST_IDLE,
        cnt:  '0,
        sh:   '0,
        drv:  1'b0,
        ptr:  '0,
        pbuf: '0,
        mask: '0,
        tmr:  '0
    };

    ctl_t cur_q, nxt_d;

    logic [PAGE_W-1:0] slot;
    logic              id_hit;

    assign slot   = cur_q.tmr[PAGE_W-1:0];
    assign id_hit = (cur_q.sh[7:4] == ID_CODE) && (cur_q.sh[3:1] == sel_i);

    // Commit port: one buffered slot per cycle at the start of the busy window
    assign busy_o      = (cur_q.st == ST_BUSY);
    assign we_o        = busy_o && (cur_q.tmr < TMR_W'(PAGE_N)) && cur_q.mask[slot];
    assign waddr_o     = {cur_q.ptr[ADDR_W-1:PAGE_W], slot};
    assign wdata_o     = cur_q.pbuf[slot];
    assign rd_addr_o   = cur_q.ptr;
    assign sda_drive_o = cur_q.drv;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.st == ST_BUSY) begin
            nxt_d.tmr = cur_q.tmr + TMR_W'(1);
            if (cur_q.tmr == TMR_W'(WR_CYCLES - 1)) begin
                nxt_d.st   = ST_IDLE;
                nxt_d.mask = '0;
                nxt_d.tmr  = '0;
            end
        end else if (ev_i.start) begin
            nxt_d.st   = ST_DEV;
            nxt_d.cnt  = '0;
            nxt_d.drv  = 1'b0;
            nxt_d.mask = '0;
        end else if (ev_i.stop) begin
            nxt_d.drv = 1'b0;
            // The stop's own clock pulse may have been counted as one bit
            if (cur_q.st == ST_WDAT && cur_q.cnt <= 4'd1 && |cur_q.mask && !wp_i) begin
                nxt_d.st  = ST_BUSY;
                nxt_d.tmr = '0;
            end else begin
                nxt_d.st = ST_IDLE;
            end
        end else begin
            unique case (cur_q.st)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (ev_i.rise && cur_q.cnt < 4'd8) begin
                        nxt_d.sh  = {cur_q.sh[BYTE_W-2:0], ev_i.sda};
                        nxt_d.cnt = cur_q.cnt + 4'd1;
                    end
                    if (ev_i.fall && cur_q.cnt == 4'd8) begin
                        if (cur_q.st == ST_DEV) begin
                            if (id_hit) begin
                                nxt_d.drv = 1'b1;
                                nxt_d.st  = ST_DEV_ACK;
                            end else begin
                                nxt_d.st  = ST_IDLE;
                            end
                        end else if (cur_q.st == ST_WADR) begin
                            nxt_d.ptr = cur_q.sh[ADDR_W-1:0];
                            nxt_d.drv = 1'b1;
                            nxt_d.st  = ST_WADR_ACK;
                        end else begin
                            nxt_d.pbuf[cur_q.ptr[PAGE_W-1:0]] = cur_q.sh;
                            nxt_d.mask[cur_q.ptr[PAGE_W-1:0]] = 1'b1;
                            nxt_d.ptr[PAGE_W-1:0] = cur_q.ptr[PAGE_W-1:0] + PAGE_W'(1);
                            nxt_d.drv = 1'b1;
                            nxt_d.st  = ST_WDAT_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev_i.fall) begin
                        nxt_d.cnt = '0;
                        if (cur_q.sh[0]) begin
                            nxt_d.sh  = rd_data_i;
                            nxt_d.drv = ~rd_data_i[BYTE_W-1];
                            nxt_d.st  = ST_RDAT;
                        end else begin
                            nxt_d.drv = 1'b0;
                            nxt_d.st  = ST_WADR;
                        end
                    end
                end
                ST_WADR_ACK, ST_WDAT_ACK: begin
                    if (ev_i.fall) begin
                        nxt_d.drv = 1'b0;
                        nxt_d.cnt = '0;
                        nxt_d.st  = ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (ev_i.rise) nxt_d.cnt = cur_q.cnt + 4'd1;
                    if (ev_i.fall) begin
                        if (cur_q.cnt == 4'd8) begin
                            nxt_d.drv = 1'b0;
                            nxt_d.ptr = cur_q.ptr + ADDR_W'(1);
                            nxt_d.st  = ST_RACK;
                        end else begin
                            nxt_d.sh  = {cur_q.sh[BYTE_W-2:0], 1'b0};
                            nxt_d.drv = ~cur_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev_i.rise) nxt_d.st = ev_i.sda ? ST_IDLE : ST_RNEXT;
                end
                ST_RNEXT: begin
                    if (ev_i.fall) begin
                        nxt_d.sh  = rd_data_i;
                        nxt_d.drv = ~rd_data_i[BYTE_W-1];
                        nxt_d.cnt = '0;
                        nxt_d.st  = ST_RDAT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= CTL_RST;
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_ee_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 3,
    parameter int WR_CYCLES = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_i,
    input  logic       wp_i,
    output logic       sda_drive_o
);

    line_ev_t          line_ev;
    logic              mem_we;
    logic              wr_busy;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [BYTE_W-1:0] mem_wdata;
    logic [BYTE_W-1:0] mem_rdata;

    twi_ee_line_mon u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (line_ev)
    );

    twi_ee_ctrl #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (line_ev),
        .sel_i       (sel_i),
        .wp_i        (wp_i),
        .rd_data_i   (mem_rdata),
        .rd_addr_o   (mem_raddr),
        .we_o        (mem_we),
        .waddr_o     (mem_waddr),
        .wdata_o     (mem_wdata),
        .busy_o      (wr_busy),
        .sda_drive_o (sda_drive_o)
    );

    twi_ee_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (mem_raddr),
        .rdata_o (mem_rdata)
    );

endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_drive_o,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr
);

    // R3: the pull-down only moves while the clock line is low
    a_r3_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_o) |-> !scl_i);

    // R6: nothing is driven while the busy window runs
    a_r6_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> !sda_drive_o);

    // R5: back-to-back commits stay inside one page
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        (mem_waddr[ADDR_W-1:PAGE_W] == $past(mem_waddr[ADDR_W-1:PAGE_W])));

    // R2: a start leaves the line released
    a_r2_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_drive_o);

    // R11: a stop leaves the line released
    a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_o);

endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_drive_o (sda_drive_o),
    .start_det   (line_ev.start),
    .stop_det    (line_ev.stop),
    .wr_busy     (wr_busy),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr)
);

// File: tb/twi_eeprom_slave_bench.sv
module twi_eeprom_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WRC        = 400;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};
    // {word address, data}: byte write, then random read expects data
    localparam logic [15:0] VECS [4] = '{16'h035A, 16'h40C3, 16'h9E11, 16'hFF7E};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic drv;
    logic line;
    int   n_chk = 0;
    int   n_fail = 0;
    logic [7:0] shadow [256];
    logic [7:0] rbuf [16];

    assign line = m_sda & ~drv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    twi_eeprom_slave #(.WR_CYCLES(WRC)) u_twi_eeprom_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (line),
        .sel_i       (SEL),
        .wp_i        (wp),
        .sda_drive_o (drv)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            m_sda = b[7 - i]; tick(Q);
            m_scl = 1'b1;     tick(Q);
            m_scl = 1'b0;     tick(Q);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~line;
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] b);
        b = '0;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b = {b[6:0], line};
            m_scl = 1'b0;
        end
        tick(2);
        m_sda = mack ? 1'b0 : 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic wait_ready(output int nacks);
        logic a;
        nacks = 0;
        for (int k = 0; k < 20; k++) begin
            bus_start();
            put_byte(DEV_W, a);
            bus_stop();
            if (a) break;
            nacks++;
        end
    endtask

    task automatic write_seq(input logic [7:0] addr, input logic [7:0] d0, input int n,
                             output logic all_ack);
        logic a;
        bus_start();
        put_byte(DEV_W, a); all_ack = a;
        put_byte(addr, a);  all_ack &= a;
        for (int i = 0; i < n; i++) begin
            put_byte(d0 + 8'(i), a);
            all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic random_read(input logic [7:0] addr, input int n);
        logic a;
        logic [7:0] b;
        bus_start();
        put_byte(DEV_W, a);
        put_byte(addr, a);
        bus_start();
        put_byte(DEV_R, a);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        bus_stop();
    endtask

    task automatic current_read(output logic [7:0] b);
        logic a;
        bus_start();
        put_byte(DEV_R, a);
        get_byte(1'b0, b);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        logic a;
        logic ok;
        logic [7:0] b;
        int nk;
        for (int i = 0; i < 256; i++) shadow[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R12: released line, counter 0, erased contents
        check(drv == 1'b0, "R12 line released", int'(drv), 0);
        current_read(b);
        check(b == 8'hFF, "R12 erased byte at counter 0", b, 8'hFF);

        // R1: wrong select bits, wrong fixed code
        bus_start(); put_byte({4'b1010, SEL ^ 3'b011, 1'b0}, a); bus_stop();
        check(a == 1'b0, "R1 select mismatch no ack", int'(a), 0);
        bus_start(); put_byte({4'b0110, SEL, 1'b0}, a); bus_stop();
        check(a == 1'b0, "R1 code mismatch no ack", int'(a), 0);
        bus_start(); put_byte(DEV_W, a); bus_stop();
        check(a == 1'b1, "R2 matching identity acked", int'(a), 1);

        // Table: byte write, poll, random read back
        for (int k = 0; k < 4; k++) begin
            write_seq(VECS[k][15:8], VECS[k][7:0], 1, ok);
            shadow[VECS[k][15:8]] = VECS[k][7:0];
            check(ok, "R4 byte write acked", int'(ok), 1);
            wait_ready(nk);
            check(nk >= 1 && nk < 20, "R6 busy withholds ack then ends", nk, 1);
            random_read(VECS[k][15:8], 1);
            check(rbuf[0] == VECS[k][7:0], "R8 random read", rbuf[0], VECS[k][7:0]);
        end

        // R7: counter after reading 0xFF wrapped to 0
        current_read(b);
        check(b == shadow[8'h00], "R7 current read after wrap", b, shadow[8'h00]);
        current_read(b);
        check(b == shadow[8'h01], "R7 current read advances", b, shadow[8'h01]);

        // R7: counter after a write is last written + 1
        write_seq(8'h22, 8'h99, 1, ok);
        shadow[8'h22] = 8'h99;
        wait_ready(nk);
        write_seq(8'h23, 8'h4D, 1, ok);
        shadow[8'h23] = 8'h4D;
        wait_ready(nk);
        random_read(8'h22, 1);
        check(rbuf[0] == 8'h99, "R4 first of two writes kept", rbuf[0], 8'h99);
        write_seq(8'h21, 8'h17, 1, ok);
        shadow[8'h21] = 8'h17;
        wait_ready(nk);
        current_read(b);
        check(b == 8'h99, "R7 counter is written address plus one", b, 8'h99);

        // R5: ten bytes from 0x15 wrap inside page 0x10..0x17
        write_seq(8'h15, 8'hA0, 10, ok);
        for (int i = 0; i < 10; i++)
            shadow[{5'b00010, 3'(3'd5 + 3'(i))}] = 8'hA0 + 8'(i);
        check(ok, "R5 page bytes acked", int'(ok), 1);
        wait_ready(nk);
        random_read(8'h10, 9);
        for (int i = 0; i < 9; i++)
            check(rbuf[i] == shadow[8'h10 + i], "R5 page content and neighbour",
                  rbuf[i], shadow[8'h10 + i]);

        // R9: sequential read crosses 255 -> 0
        random_read(8'hFE, 3);
        check(rbuf[0] == shadow[8'hFE], "R9 seq byte 0xFE", rbuf[0], shadow[8'hFE]);
        check(rbuf[1] == 8'h7E, "R9 seq byte 0xFF", rbuf[1], 8'h7E);
        check(rbuf[2] == shadow[8'h00], "R9 seq wraps to 0", rbuf[2], shadow[8'h00]);

        // R10: protect on
        wp = 1'b1;
        write_seq(8'h30, 8'h12, 2, ok);
        check(ok, "R10 protected bytes still acked", int'(ok), 1);
        wait_ready(nk);
        check(nk == 0, "R10 no busy window", nk, 0);
        wp = 1'b0;
        random_read(8'h30, 2);
        check(rbuf[0] == 8'hFF && rbuf[1] == 8'hFF, "R10 nothing stored", rbuf[0], 8'hFF);

        // R11: stop after four data bits
        bus_start(); put_byte(DEV_W, a); put_byte(8'h50, a);
        send_bits(8'h3C, 4);
        bus_stop();
        wait_ready(nk);
        check(nk == 0, "R11 stop abort no busy", nk, 0);
        // R11: repeated start after five data bits
        bus_start(); put_byte(DEV_W, a); put_byte(8'h51, a);
        send_bits(8'hC5, 5);
        bus_start(); put_byte(DEV_W, a); bus_stop();
        check(a == 1'b1, "R11 start abort no busy", int'(a), 1);
        random_read(8'h50, 2);
        check(rbuf[0] == 8'hFF && rbuf[1] == 8'hFF, "R11 aborted bytes not stored",
              rbuf[0], 8'hFF);

        // R8: address load alone starts no busy window
        bus_start(); put_byte(DEV_W, a); put_byte(8'h70, a); bus_stop();
        wait_ready(nk);
        check(nk == 0, "R8 address-only no busy", nk, 0);
        check(drv == 1'b0, "R2 line released at end", int'(drv), 0);

        finish_run();
    end

endmodule